// File: doc/BRIEF.md
# Special Register and Interrupt Control Executor

This unit carries out the small group of prefixed control instructions of an 8-bit processor that touch the interrupt machinery. It handles moves between the accumulator and two special registers: the interrupt page register and the memory refresh counter. It also handles the choice of interrupt response mode, and the two return-from-interrupt forms. The decoded second opcode byte comes in with a one-cycle strobe, together with the current accumulator and the second interrupt-enable latch. The unit holds the page register, the refresh counter, the interrupt mode and the first interrupt-enable latch. For each instruction it produces a new accumulator value with flags, a request to pop the return address, or a pulse that reports an unknown opcode.

The stack pop, the opcode fetch and the general ALU are handled elsewhere. The unit only signals a pop through `pop_req`. Every result is registered, so each outcome appears one clock after the strobe. An input reset synchronizer releases the internal reset two clocks after `rst_n` rises.

Top module: `spc_ctl_exec`

## Requirements
- R1: Opcode 0x47 loads `acc_in` into the page register (`i_out`), and opcode 0x4F loads `acc_in` into the refresh counter (`r_out`); in that case the loaded value replaces the increment. Neither opcode raises `acc_we`, `flags_we` or `pop_req`.
- R2: Opcode 0x57 writes the page register value to `acc_out`. Opcode 0x5F writes the refresh counter value to `acc_out`, and that value already includes the increment of this instruction. Both opcodes raise `acc_we` for one cycle.
- R3: With those two loads, `flags_we` pulses. `flags_out` then carries the sign (bit 7) equal to the result's bit 7, zero (bit 6) set when the result is 0, half-carry (bit 4) and subtract (bit 1) cleared, and parity/overflow (bit 2) equal to `iff2_in`. Bits 5, 3 and 0 are 0. Between writes, `acc_out` and `flags_out` hold their values.
- R4: Opcodes 0x45, 0x55, 0x5D, 0x65, 0x6D, 0x75 and 0x7D pulse `pop_req` and copy `iff2_in` into `iff1_out`.
- R5: Opcode 0x4D pulses `pop_req` and leaves `iff1_out` unchanged.
- R6: `im_out` becomes 0 after 0x46, 0x4E, 0x66 or 0x6E, becomes 1 after 0x56 or 0x76, and becomes 2 after 0x5E or 0x7E.
- R7: Every supported opcode other than 0x4F increments bits 6:0 of the refresh counter, wrapping from 0x7F to 0x00, and keeps bit 7.
- R8: Any other opcode pulses `bad_op` for one cycle and changes no register, no output value and no refresh count.
- R9: After reset, `i_out`, `r_out`, `im_out`, `iff1_out`, `acc_out` and `flags_out` are 0, and no pulse output is high.
- R10: While `exec_vld` is low, no output changes and no pulse is raised.
- R11: All results and pulses appear in the cycle after the strobed edge. Each pulse lasts one cycle for each strobe, and strobes on consecutive cycles are each executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_vld | input | 1 | Strobe: execute `op_byte` this cycle |
| op_byte | input | 8 | Second opcode byte |
| acc_in | input | 8 | Current accumulator |
| iff2_in | input | 1 | Current second interrupt-enable latch |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write pulse |
| i_out | output | 8 | Interrupt page register |
| r_out | output | 8 | Refresh counter |
| im_out | output | 2 | Interrupt mode |
| iff1_out | output | 1 | First interrupt-enable latch |
| flags_out | output | 8 | Flag byte |
| flags_we | output | 1 | Flag write pulse |
| pop_req | output | 1 | Request to pop the return address |
| bad_op | output | 1 | Unknown opcode pulse |

## Verification
Every register, every held output and every pulse is due exactly one clock after the edge that sampled the strobe. No result is due later than that. The bench model applies each strobe at the same rising edge as the design, and it compares all outputs at the following falling edge. This way each result is checked in the cycle it first becomes visible, and each one-cycle pulse is checked to have dropped one cycle later. Because the model also follows the two-stage reset release, no comparison is made while the internal reset is still held.

// File: rtl/spc_ctl_pkg.sv
package spc_ctl_pkg;
  typedef enum logic [3:0] {
    K_NONE,
    K_LD_IA,
    K_LD_RA,
    K_LD_AI,
    K_LD_AR,
    K_RETN,
    K_RETI,
    K_IM0,
    K_IM1,
    K_IM2,
    K_BAD
  } kind_e;

  localparam int unsigned FL_S  = 7;
  localparam int unsigned FL_Z  = 6;
  localparam int unsigned FL_H  = 4;
  localparam int unsigned FL_PV = 2;
  localparam int unsigned FL_N  = 1;
  localparam int unsigned FLW   = 8;
endpackage

// File: rtl/spc_ctl_decode.sv
module spc_ctl_decode
  import spc_ctl_pkg::*;
#(
  parameter bit ALIAS_EN = 1'b1
) (
  input  logic       exec_vld,
  input  logic [7:0] op_byte,
  output kind_e      kind
);
  kind_e alias_kind;

  // Undecoded encodings: either mapped onto their documented twins or rejected.
  generate
    if (ALIAS_EN) begin : g_alias
      always_comb begin
        unique case (op_byte)
          8'h55, 8'h5D, 8'h65, 8'h6D, 8'h75, 8'h7D: alias_kind = K_RETN;
          8'h4E, 8'h66, 8'h6E:                      alias_kind = K_IM0;
          8'h76:                                    alias_kind = K_IM1;
          8'h7E:                                    alias_kind = K_IM2;
          default:                                  alias_kind = K_BAD;
        endcase
      end
    end else begin : g_noalias
      assign alias_kind = K_BAD;
    end
  endgenerate

  always_comb begin
    if (!exec_vld) begin
      kind = K_NONE;
    end else begin
      unique case (op_byte)
        8'h47:   kind = K_LD_IA;
        8'h4F:   kind = K_LD_RA;
        8'h57:   kind = K_LD_AI;
        8'h5F:   kind = K_LD_AR;
        8'h45:   kind = K_RETN;
        8'h4D:   kind = K_RETI;
        8'h46:   kind = K_IM0;
        8'h56:   kind = K_IM1;
        8'h5E:   kind = K_IM2;
        default: kind = alias_kind;
      endcase
    end
  end
endmodule

// File: rtl/spc_ctl_spreg.sv
module spc_ctl_spreg
  import spc_ctl_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned IMW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kind_e         kind,
  input  logic [DW-1:0] acc_in,
  input  logic          iff2_in,
  output logic [DW-1:0] i_q,
  output logic [DW-1:0] r_q,
  output logic [DW-1:0] r_seen,
  output logic [IMW-1:0] im_q,
  output logic          iff1_q
);
  localparam int unsigned RCW = DW - 1;

  logic [DW-1:0]  i_d, r_d;
  logic [IMW-1:0] im_d;
  logic           iff1_d;
  logic           adv;

  assign adv    = (kind != K_NONE) && (kind != K_BAD);
  assign r_seen = {r_q[DW-1], r_q[RCW-1:0] + {{(RCW-1){1'b0}}, 1'b1}};

  always_comb begin
    i_d    = i_q;
    r_d    = r_q;
    im_d   = im_q;
    iff1_d = iff1_q;
    if (adv) r_d = r_seen;
    unique case (kind)
      K_LD_IA: i_d    = acc_in;
      K_LD_RA: r_d    = acc_in;
      K_RETN:  iff1_d = iff2_in;
      K_IM0:   im_d   = IMW'(0);
      K_IM1:   im_d   = IMW'(1);
      K_IM2:   im_d   = IMW'(2);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q    <= '0;
      r_q    <= '0;
      im_q   <= '0;
      iff1_q <= 1'b0;
    end else if (adv) begin
      i_q    <= i_d;
      r_q    <= r_d;
      im_q   <= im_d;
      iff1_q <= iff1_d;
    end
  end
endmodule

// File: rtl/spc_ctl_result.sv
module spc_ctl_result
  import spc_ctl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  kind_e          kind,
  input  logic [DW-1:0]  i_q,
  input  logic [DW-1:0]  r_seen,
  input  logic           iff2_in,
  output logic [DW-1:0]  acc_q,
  output logic [FLW-1:0] flags_q,
  output logic           acc_we_q,
  output logic           pop_q,
  output logic           bad_q
);
  logic [DW-1:0]  val;
  logic [FLW-1:0] fl_d;
  logic           load_a, pop_d, bad_d;

  assign load_a = (kind == K_LD_AI) || (kind == K_LD_AR);
  assign pop_d  = (kind == K_RETN) || (kind == K_RETI);
  assign bad_d  = (kind == K_BAD);
  assign val    = (kind == K_LD_AI) ? i_q : r_seen;

  always_comb begin
    fl_d        = '0;
    fl_d[FL_S]  = val[DW-1];
    fl_d[FL_Z]  = (val == '0);
    fl_d[FL_H]  = 1'b0;
    fl_d[FL_N]  = 1'b0;
    fl_d[FL_PV] = iff2_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (load_a) begin
      acc_q   <= val;
      flags_q <= fl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_we_q <= 1'b0;
      pop_q    <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      acc_we_q <= load_a;
      pop_q    <= pop_d;
      bad_q    <= bad_d;
    end
  end
endmodule

// File: rtl/spc_ctl_exec.sv
module spc_ctl_exec
  import spc_ctl_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned IMW      = 2,
  parameter bit          ALIAS_EN = 1'b1,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_vld,
  input  logic [7:0]     op_byte,
  input  logic [DW-1:0]  acc_in,
  input  logic           iff2_in,
  output logic [DW-1:0]  acc_out,
  output logic           acc_we,
  output logic [DW-1:0]  i_out,
  output logic [DW-1:0]  r_out,
  output logic [IMW-1:0] im_out,
  output logic           iff1_out,
  output logic [FLW-1:0] flags_out,
  output logic           flags_we,
  output logic           pop_req,
  output logic           bad_op
);
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;
  kind_e             kind;
  logic [DW-1:0]     r_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  spc_ctl_decode #(.ALIAS_EN(ALIAS_EN)) u_dec (
    .exec_vld (exec_vld),
    .op_byte  (op_byte),
    .kind     (kind)
  );

  spc_ctl_spreg #(.DW(DW), .IMW(IMW)) u_spreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .kind    (kind),
    .acc_in  (acc_in),
    .iff2_in (iff2_in),
    .i_q     (i_out),
    .r_q     (r_out),
    .r_seen  (r_seen),
    .im_q    (im_out),
    .iff1_q  (iff1_out)
  );

  spc_ctl_result #(.DW(DW)) u_res (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .kind     (kind),
    .i_q      (i_out),
    .r_seen   (r_seen),
    .iff2_in  (iff2_in),
    .acc_q    (acc_out),
    .flags_q  (flags_out),
    .acc_we_q (acc_we),
    .pop_q    (pop_req),
    .bad_q    (bad_op)
  );

  assign flags_we = acc_we;
endmodule

// File: rtl/spc_ctl_exec_chk.sv
module spc_ctl_exec_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned IMW = 2
) (
  input logic           clk,
  input logic           rst_sync_n,
  input logic           exec_vld,
  input logic [DW-1:0]  acc_out,
  input logic           acc_we,
  input logic [DW-1:0]  i_out,
  input logic [DW-1:0]  r_out,
  input logic [IMW-1:0] im_out,
  input logic           iff1_out,
  input logic [7:0]     flags_out,
  input logic           pop_req,
  input logic           bad_op
);
  assert_flags_track_acc_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_we |-> (flags_out[7] == acc_out[DW-1]) && (flags_out[6] == (acc_out == '0))
               && !flags_out[4] && !flags_out[1]);

  assert_refresh_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop_req |-> (r_out[DW-2:0] == $past(r_out[DW-2:0]) + 1'b1) && (r_out[DW-1] == $past(r_out[DW-1])));

  assert_unknown_no_state_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_op |-> $stable(i_out) && $stable(r_out) && $stable(im_out) && $stable(iff1_out)
               && $stable(acc_out) && !acc_we && !pop_req);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(exec_vld) |-> $stable(i_out) && $stable(r_out) && $stable(im_out)
                         && $stable(iff1_out) && $stable(acc_out) && $stable(flags_out)
                         && !acc_we && !pop_req && !bad_op);

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({acc_we, pop_req, bad_op}));

  assert_im_legal_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    im_out != IMW'(3));
endmodule

bind spc_ctl_exec spc_ctl_exec_chk #(.DW(DW), .IMW(IMW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .exec_vld   (exec_vld),
  .acc_out    (acc_out),
  .acc_we     (acc_we),
  .i_out      (i_out),
  .r_out      (r_out),
  .im_out     (im_out),
  .iff1_out   (iff1_out),
  .flags_out  (flags_out),
  .pop_req    (pop_req),
  .bad_op     (bad_op)
);

// File: tb/spc_ctl_exec_tb_top.sv
`timescale 1ns/1ps
module spc_ctl_exec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       exec_vld = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic [7:0] acc_in = 8'h00;
  logic       iff2_in = 1'b0;
  logic [7:0] acc_out, i_out, r_out, flags_out;
  logic [1:0] im_out;
  logic       acc_we, iff1_out, flags_we, pop_req, bad_op;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spc_ctl_exec dut_i (
    .clk(clk), .rst_n(rst_n), .exec_vld(exec_vld), .op_byte(op_byte),
    .acc_in(acc_in), .iff2_in(iff2_in), .acc_out(acc_out), .acc_we(acc_we),
    .i_out(i_out), .r_out(r_out), .im_out(im_out), .iff1_out(iff1_out),
    .flags_out(flags_out), .flags_we(flags_we), .pop_req(pop_req), .bad_op(bad_op)
  );

  // Behavioural reference model
  logic [1:0] ms = 2'b00;
  logic [7:0] mI = 0, mR = 0, mAcc = 0, mFl = 0;
  logic [1:0] mIM = 0;
  logic       mIFF1 = 0, mWe = 0, mPop = 0, mBad = 0;

  task automatic model_clear();
    mI = 0; mR = 0; mAcc = 0; mFl = 0; mIM = 0; mIFF1 = 0;
    mWe = 0; mPop = 0; mBad = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] rn, v;
    if (!rst_n) begin
      ms = 2'b00;
      model_clear();
    end else begin
      if (!ms[1]) begin
        model_clear();
      end else begin
        mWe = 0; mPop = 0; mBad = 0;
        if (exec_vld) begin
          rn = {mR[7], mR[6:0] + 7'd1};
          if (op_byte == 8'h47) begin mI = acc_in; mR = rn; end
          else if (op_byte == 8'h4F) mR = acc_in;
          else if (op_byte == 8'h57 || op_byte == 8'h5F) begin
            v = (op_byte == 8'h57) ? mI : rn;
            mR = rn; mAcc = v; mWe = 1;
            mFl = {v[7], v == 8'h00, 3'b000, iff2_in, 2'b00};
          end
          else if (op_byte inside {8'h45, 8'h55, 8'h5D, 8'h65, 8'h6D, 8'h75, 8'h7D}) begin
            mIFF1 = iff2_in; mPop = 1; mR = rn;
          end
          else if (op_byte == 8'h4D) begin mPop = 1; mR = rn; end
          else if (op_byte inside {8'h46, 8'h4E, 8'h66, 8'h6E}) begin mIM = 0; mR = rn; end
          else if (op_byte inside {8'h56, 8'h76}) begin mIM = 1; mR = rn; end
          else if (op_byte inside {8'h5E, 8'h7E}) begin mIM = 2; mR = rn; end
          else mBad = 1;
        end
      end
      ms = {ms[0], 1'b1};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Compare everything on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (ms[1] && !done) begin
      chk("R1 i_out", 32'(i_out), 32'(mI));
      chk("R7 r_out", 32'(r_out), 32'(mR));
      chk("R2 acc_out", 32'(acc_out), 32'(mAcc));
      chk("R11 acc_we", 32'(acc_we), 32'(mWe));
      chk("R3 flags_out", 32'(flags_out), 32'(mFl));
      chk("R1 flags_we", 32'(flags_we), 32'(mWe));
      chk("R6 im_out", 32'(im_out), 32'(mIM));
      chk("R4 iff1_out", 32'(iff1_out), 32'(mIFF1));
      chk("R5 pop_req", 32'(pop_req), 32'(mPop));
      chk("R8 bad_op", 32'(bad_op), 32'(mBad));
    end
  end

  task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic f);
    exec_vld = 1'b1; op_byte = op; acc_in = a; iff2_in = f;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    exec_vld = 1'b0; op_byte = 8'hFF; acc_in = 8'h3C;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R9: reset values seen at the ports
    chk("R9 i_out", 32'(i_out), 0);
    chk("R9 r_out", 32'(r_out), 0);
    chk("R9 im_out", 32'(im_out), 0);
    chk("R9 iff1_out", 32'(iff1_out), 0);
    chk("R9 pulses", 32'({acc_we, pop_req, bad_op}), 0);
    // R1 loads of I and R
    issue(8'h47, 8'hA5, 1'b0); idle(2);
    issue(8'h4F, 8'h7E, 1'b0); idle(1);
    // R7 wrap of bits 6:0 with bit 7 clear, then with bit 7 set
    issue(8'h46, 8'h00, 1'b0); issue(8'h46, 8'h00, 1'b0); idle(1);
    issue(8'h4F, 8'hFF, 1'b0); issue(8'h56, 8'h00, 1'b0); idle(1);
    // R2 R3: loads into the accumulator with both IFF2 values
    issue(8'h57, 8'h00, 1'b1); idle(1);
    issue(8'h5F, 8'h00, 1'b0); idle(1);
    issue(8'h47, 8'h00, 1'b0); issue(8'h57, 8'h11, 1'b0); idle(1);
    issue(8'h4F, 8'h7F, 1'b0); issue(8'h5F, 8'h00, 1'b1); idle(2);
    // R4 every restoring return alias, R5 plain return
    issue(8'h45, 8'h00, 1'b1); idle(1);
    issue(8'h4D, 8'h00, 1'b0); idle(1);
    issue(8'h55, 8'h00, 1'b0); issue(8'h5D, 8'h00, 1'b1); issue(8'h65, 8'h00, 1'b0);
    issue(8'h6D, 8'h00, 1'b1); issue(8'h4D, 8'h00, 1'b0); issue(8'h75, 8'h00, 1'b0);
    issue(8'h7D, 8'h00, 1'b1); idle(2);
    // R6 all mode aliases
    issue(8'h5E, 8'h00, 1'b0); issue(8'h4E, 8'h00, 1'b0); issue(8'h7E, 8'h00, 1'b0);
    issue(8'h66, 8'h00, 1'b0); issue(8'h76, 8'h00, 1'b0); issue(8'h6E, 8'h00, 1'b0);
    idle(1);
    // R8 unknown opcodes leave state alone
    issue(8'h5E, 8'h00, 1'b0);
    issue(8'h00, 8'h99, 1'b1); issue(8'hB0, 8'h99, 1'b1); issue(8'h4C, 8'h99, 1'b0);
    issue(8'h77, 8'h99, 1'b1); issue(8'h44, 8'h99, 1'b0); idle(2);
    // R10: idle gap with changing data inputs
    for (int k = 0; k < 6; k++) begin
      exec_vld = 1'b0; op_byte = 8'h47 + 8'(k); acc_in = 8'(k * 37); iff2_in = k[0];
      @(negedge clk);
    end
    // R11: long back-to-back mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ops [8];
      ops = '{8'h47, 8'h57, 8'h5F, 8'h45, 8'h4D, 8'h7E, 8'h01, 8'h4F};
      issue(ops[k % 8], 8'(k * 29 + 3), k[1]);
    end
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule